// File: doc/BRIEF.md
# Upset-Tolerant Dual-Copy Register File

This block is a register file with two read ports and one write port that keeps working through single-event upsets in its storage. Every entry is held twice, in a primary bank and a shadow bank. Each entry in each bank carries one even-parity bit per data byte, and that parity is generated from the write data when the word is written. A read always returns the primary copy's data in a fixed single cycle. Parity is checked next to that path, so checking never delays the data.

When the primary copy of a word fails its parity check and the shadow copy is clean, the block flags a retry on that read port. The pipeline around it then re-issues the instruction. In the same clock edge, the block copies the shadow word over the primary word, so the re-issued read gets good data. If both copies are bad, the block flags an unrecoverable error instead. If only the shadow copy is bad, the block rewrites it from the primary copy without telling the pipeline. A saturating counter records the recovered events.

A test input flips one chosen stored bit of either bank. This lets upsets be created on purpose.

Top module: `seu_rf`

## Requirements
- R1: A word written on `wr_data` at `wr_addr` is stored in both banks. A read of that address in a later cycle returns it on the read port's data output one clock after the address is presented.
- R2: Both read ports and the write port work in the same cycle, each on its own address.
- R3: A stored entry is 36 bits wide. Bits 31..0 hold the data, and bit 32+k holds the even parity of data byte k (bits 8k+7..8k). When `inj_en` is high, stored bit `inj_bit` at `inj_addr` is inverted in the shadow bank if `inj_dup` is 1, or in the primary bank if it is 0. The flip is only seen when that entry is read.
- R4: If a read address equals `wr_addr` while `wr_en` is high, the port returns `wr_data` with retry and fatal low, and no repair takes place.
- R5: A read whose primary entry fails parity while its shadow entry passes returns the primary data as stored and raises that port's retry for that one result. In the same edge, the primary entry is overwritten from the shadow, so a later read returns the correct data with retry low.
- R6: A read where both entries fail parity raises that port's fatal output, keeps retry low and repairs nothing. A second read reports fatal again.
- R7: A read where the primary entry passes and the shadow entry fails returns correct data with retry and fatal low, and the shadow entry is rewritten from the primary. Corrupting the primary entry afterwards then gives a retry, not a fatal.
- R8: `err_count` rises by one for each port that reports a retry in a cycle, so by two if both ports do. It saturates at 2^CNT_W-1, and fatal results do not change it.
- R9: While `rst_n` is low, all data, retry and fatal outputs and `err_count` are zero.
- R10: An injection aimed at the address being written in the same cycle has no effect. The entry holds the new write data and reads back clean.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset of the output registers and counter |
| wr_en | input | 1 | Write enable |
| wr_addr | input | AW (8) | Write address |
| wr_data | input | DW (32) | Write data |
| ra_addr | input | AW (8) | Read port A address |
| rb_addr | input | AW (8) | Read port B address |
| inj_en | input | 1 | Flip one stored bit this cycle |
| inj_dup | input | 1 | Injection target: 0 primary bank, 1 shadow bank |
| inj_addr | input | AW (8) | Injection entry |
| inj_bit | input | 6 | Injection bit position within the 36-bit entry |
| ra_data | output | DW (32) | Read port A data |
| ra_retry | output | 1 | Port A recovered error: re-issue the instruction |
| ra_fatal | output | 1 | Port A error in both copies |
| rb_data | output | DW (32) | Read port B data |
| rb_retry | output | 1 | Port B recovered error |
| rb_fatal | output | 1 | Port B error in both copies |
| err_count | output | CNT_W (4) | Saturating count of recovered errors |

## Verification
Data, retry, fatal and the counter update for a read all appear exactly one clock edge after the cycle that presents the address. Repairs and injections take effect on that same edge, so they are visible to a read issued in the very next cycle. The driver task updates a reference model and, in the same cycle it drives the inputs, queues the expected values for both ports and the counter, each stamped with the cycle in which it is due. The monitor compares the outputs with those values half a cycle after the due edge. Follow-up reads in the next cycle confirm each repair and each ignored injection.

// File: rtl/seu_rf_pkg.sv
package seu_rf_pkg;

    // Outcome of one read after parity checking of both copies.
    typedef enum logic [1:0] {
        RD_CLEAN  = 2'd0,
        RD_RETRY  = 2'd1,
        RD_FATAL  = 2'd2,
        RD_BYPASS = 2'd3
    } rd_kind_e;

endpackage

// File: rtl/seu_rf_par.sv
// Even parity per byte of a data word.
module seu_rf_par #(
    parameter int DW = 32
) (
    input  logic [DW-1:0]   data,
    output logic [DW/8-1:0] par
);
    localparam int NB = DW / 8;

    for (genvar g = 0; g < NB; g++) begin : g_byte
        assign par[g] = ^data[g*8 +: 8];
    end
endmodule

// File: rtl/seu_rf_bank.sv
// One copy of the array: asynchronous read ports, one write, repair writes
// and a single-bit inversion for upset injection.
module seu_rf_bank #(
    parameter int DEPTH = 136,
    parameter int AW    = 8,
    parameter int WW    = 36,
    parameter int NRD   = 2,
    parameter int IB    = $clog2(WW)
) (
    input  logic              clk,
    input  logic              we,
    input  logic [AW-1:0]     waddr,
    input  logic [WW-1:0]     wword,
    input  logic [NRD-1:0]    fix_en,
    input  logic [NRD*AW-1:0] fix_addr,
    input  logic [NRD*WW-1:0] fix_word,
    input  logic              inj_en,
    input  logic [AW-1:0]     inj_addr,
    input  logic [IB-1:0]     inj_bit,
    input  logic [NRD*AW-1:0] raddr,
    output logic [NRD*WW-1:0] rword
);
    logic [WW-1:0] mem [DEPTH];

    // Later assignments win: repair, then injection, then the normal write.
    always_ff @(posedge clk) begin
        for (int p = 0; p < NRD; p++) begin
            if (fix_en[p]) mem[fix_addr[p*AW +: AW]] <= fix_word[p*WW +: WW];
        end
        if (inj_en) mem[inj_addr][inj_bit] <= ~mem[inj_addr][inj_bit];
        if (we) mem[waddr] <= wword;
    end

    for (genvar p = 0; p < NRD; p++) begin : g_rd
        assign rword[p*WW +: WW] = mem[raddr[p*AW +: AW]];
    end
endmodule

// File: rtl/seu_rf_port.sv
// Per-read-port check: classifies the read and requests repairs.
module seu_rf_port
    import seu_rf_pkg::*;
#(
    parameter int DW = 32,
    parameter int WW = DW + DW / 8
) (
    input  logic          byp,
    input  logic [DW-1:0] wdata,
    input  logic [WW-1:0] pri_word,
    input  logic [WW-1:0] dup_word,
    output logic [DW-1:0] data_o,
    output rd_kind_e      kind_o,
    output logic          fix_pri,
    output logic          fix_dup
);
    localparam int NB = DW / 8;

    logic [NB-1:0] pri_par, dup_par;
    logic          pri_ok, dup_ok;

    seu_rf_par #(.DW(DW)) u_pri_chk (.data(pri_word[DW-1:0]), .par(pri_par));
    seu_rf_par #(.DW(DW)) u_dup_chk (.data(dup_word[DW-1:0]), .par(dup_par));

    assign pri_ok = (pri_par == pri_word[WW-1:DW]);
    assign dup_ok = (dup_par == dup_word[WW-1:DW]);

    always_comb begin
        data_o  = pri_word[DW-1:0];
        kind_o  = RD_CLEAN;
        fix_pri = 1'b0;
        fix_dup = 1'b0;
        if (byp) begin
            data_o = wdata;
            kind_o = RD_BYPASS;
        end else if (!pri_ok && dup_ok) begin
            kind_o  = RD_RETRY;
            fix_pri = 1'b1;
        end else if (!pri_ok) begin
            kind_o = RD_FATAL;
        end else if (!dup_ok) begin
            fix_dup = 1'b1;
        end
    end
endmodule

// File: rtl/seu_rf.sv
module seu_rf
    import seu_rf_pkg::*;
#(
    parameter int DEPTH = 136,
    parameter int DW    = 32,
    parameter int AW    = 8,
    parameter int CNT_W = 4
) (
    input  logic                          clk,
    input  logic                          rst_n,
    input  logic                          wr_en,
    input  logic [AW-1:0]                 wr_addr,
    input  logic [DW-1:0]                 wr_data,
    input  logic [AW-1:0]                 ra_addr,
    input  logic [AW-1:0]                 rb_addr,
    input  logic                          inj_en,
    input  logic                          inj_dup,
    input  logic [AW-1:0]                 inj_addr,
    input  logic [$clog2(DW+DW/8)-1:0]    inj_bit,
    output logic [DW-1:0]                 ra_data,
    output logic                          ra_retry,
    output logic                          ra_fatal,
    output logic [DW-1:0]                 rb_data,
    output logic                          rb_retry,
    output logic                          rb_fatal,
    output logic [CNT_W-1:0]              err_count
);
    localparam int NB  = DW / 8;
    localparam int WW  = DW + NB;
    localparam int IB  = $clog2(WW);
    localparam int NRD = 2;
    localparam logic [CNT_W-1:0] CMAX = '1;

    typedef struct packed {
        logic [DW-1:0]    da;
        logic             ra;
        logic             fa;
        logic [DW-1:0]    db;
        logic             rb;
        logic             fb;
        logic [CNT_W-1:0] cnt;
    } st_t;

    st_t st_d, st_q;

    logic [NB-1:0]       wpar;
    logic [WW-1:0]       wword;
    logic [NRD*AW-1:0]   raddr;
    logic [NRD*WW-1:0]   rw [2];
    logic [NRD*WW-1:0]   fix_word [2];
    logic [NRD-1:0]      fix_pri, fix_dup;
    logic [DW-1:0]       pdata [NRD];
    rd_kind_e            pkind [NRD];

    seu_rf_par #(.DW(DW)) u_wpar (.data(wr_data), .par(wpar));
    assign wword = {wpar, wr_data};
    assign raddr = {rb_addr, ra_addr};

    // Primary bank is repaired from the shadow read, the shadow from the primary.
    assign fix_word[0] = rw[1];
    assign fix_word[1] = rw[0];

    for (genvar c = 0; c < 2; c++) begin : g_bank
        seu_rf_bank #(
            .DEPTH(DEPTH), .AW(AW), .WW(WW), .NRD(NRD), .IB(IB)
        ) u_bank (
            .clk     (clk),
            .we      (wr_en),
            .waddr   (wr_addr),
            .wword   (wword),
            .fix_en  ((c == 0) ? fix_pri : fix_dup),
            .fix_addr(raddr),
            .fix_word(fix_word[c]),
            .inj_en  (inj_en && (inj_dup == c[0])),
            .inj_addr(inj_addr),
            .inj_bit (inj_bit),
            .raddr   (raddr),
            .rword   (rw[c])
        );
    end

    for (genvar p = 0; p < NRD; p++) begin : g_port
        seu_rf_port #(.DW(DW), .WW(WW)) u_port (
            .byp     (wr_en && (wr_addr == raddr[p*AW +: AW])),
            .wdata   (wr_data),
            .pri_word(rw[0][p*WW +: WW]),
            .dup_word(rw[1][p*WW +: WW]),
            .data_o  (pdata[p]),
            .kind_o  (pkind[p]),
            .fix_pri (fix_pri[p]),
            .fix_dup (fix_dup[p])
        );
    end

    always_comb begin
        logic [CNT_W+1:0] sum;
        logic [1:0]       nret;
        st_d    = st_q;
        st_d.da = pdata[0];
        st_d.ra = (pkind[0] == RD_RETRY);
        st_d.fa = (pkind[0] == RD_FATAL);
        st_d.db = pdata[1];
        st_d.rb = (pkind[1] == RD_RETRY);
        st_d.fb = (pkind[1] == RD_FATAL);
        nret    = {1'b0, st_d.ra} + {1'b0, st_d.rb};
        sum     = {2'b00, st_q.cnt} + {{CNT_W{1'b0}}, nret};
        st_d.cnt = (sum > {2'b00, CMAX}) ? CMAX : sum[CNT_W-1:0];
    end

    always_ff @(posedge clk) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ra_data   = st_q.da;
    assign ra_retry  = st_q.ra;
    assign ra_fatal  = st_q.fa;
    assign rb_data   = st_q.db;
    assign rb_retry  = st_q.rb;
    assign rb_fatal  = st_q.fb;
    assign err_count = st_q.cnt;

    // R4: a same-cycle write is forwarded and never flagged.
    a_r4_bypass_a: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && (wr_addr == ra_addr)) |->
            (ra_data == $past(wr_data) && !ra_retry && !ra_fatal));
    a_r4_bypass_b: assert property (@(posedge clk) disable iff (!rst_n)
        $past(wr_en && (wr_addr == rb_addr)) |->
            (rb_data == $past(wr_data) && !rb_retry && !rb_fatal));
    // R8: counter only rises, moves on retries, otherwise holds.
    a_r8_cnt_mono: assert property (@(posedge clk) disable iff (!rst_n)
        err_count >= $past(err_count));
    a_r8_cnt_step: assert property (@(posedge clk) disable iff (!rst_n)
        (ra_retry || rb_retry) |-> (err_count == CMAX || err_count != $past(err_count)));
    a_r8_cnt_hold: assert property (@(posedge clk) disable iff (!rst_n)
        (!ra_retry && !rb_retry) |-> $stable(err_count));
endmodule

// File: tb/seu_rf_test.sv
module seu_rf_test;
    localparam int CLK_NS = 10;
    localparam int DEPTH  = 136;
    localparam int CMAX   = 15;

    logic        clk = 1'b0, rst_n = 1'b0;
    logic        wr_en = 1'b0, inj_en = 1'b0, inj_dup = 1'b0;
    logic [7:0]  wr_addr = '0, ra_addr = '0, rb_addr = '0, inj_addr = '0;
    logic [31:0] wr_data = '0;
    logic [5:0]  inj_bit = '0;
    logic [31:0] ra_data, rb_data;
    logic        ra_retry, ra_fatal, rb_retry, rb_fatal;
    logic [3:0]  err_count;

    seu_rf uut (
        .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_addr(wr_addr), .wr_data(wr_data),
        .ra_addr(ra_addr), .rb_addr(rb_addr), .inj_en(inj_en), .inj_dup(inj_dup),
        .inj_addr(inj_addr), .inj_bit(inj_bit), .ra_data(ra_data), .ra_retry(ra_retry),
        .ra_fatal(ra_fatal), .rb_data(rb_data), .rb_retry(rb_retry), .rb_fatal(rb_fatal),
        .err_count(err_count)
    );

    always #(CLK_NS/2) clk = ~clk;

    typedef struct {
        int          due;
        int          port;
        logic [33:0] exp;
        string       tag;
    } item_t;

    item_t       sbq [$];
    int          cyc = 0, total = 0, bad = 0, mcnt = 0;
    logic [35:0] mpri [DEPTH];
    logic [35:0] mdup [DEPTH];

    always @(posedge clk) cyc <= cyc + 1;

    function automatic logic [35:0] mk(input logic [31:0] d);
        return {^d[31:24], ^d[23:16], ^d[15:8], ^d[7:0], d};
    endfunction

    function automatic logic good(input logic [35:0] w);
        return mk(w[31:0]) == w;
    endfunction

    task automatic check(input string tag, input logic [33:0] got, input logic [33:0] exp);
        total++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s got=%h exp=%h", tag, got, exp);
        end
    endtask

    // Monitor: compares results half a cycle after the edge they are due on.
    always begin
        item_t it;
        logic [33:0] got;
        @(negedge clk);
        #1;
        while (sbq.size() > 0 && sbq[0].due <= cyc) begin
            it = sbq.pop_front();
            if (it.port == 0)      got = {ra_fatal, ra_retry, ra_data};
            else if (it.port == 1) got = {rb_fatal, rb_retry, rb_data};
            else                   got = {30'd0, err_count};
            check($sformatf("%s port%0d", it.tag, it.port), got, it.exp);
        end
    end

    // Driver: one cycle of stimulus plus model update and expectations.
    task automatic op(input logic w, input logic [7:0] wa, input logic [31:0] wd,
                      input logic [7:0] a0, input logic [7:0] a1,
                      input logic ie, input logic id, input logic [7:0] ia,
                      input logic [5:0] ib, input string tag);
        logic [7:0] a;
        logic       pok, dok;
        logic [1:0] fp, fd;
        int         nret;
        item_t      it;
        @(negedge clk);
        wr_en = w; wr_addr = wa; wr_data = wd; ra_addr = a0; rb_addr = a1;
        inj_en = ie; inj_dup = id; inj_addr = ia; inj_bit = ib;
        fp = '0; fd = '0; nret = 0;
        for (int p = 0; p < 2; p++) begin
            a = (p == 0) ? a0 : a1;
            it.due = cyc + 1; it.port = p; it.tag = tag;
            if (w && wa == a) begin
                it.exp = {2'b00, wd};
            end else begin
                pok = good(mpri[a]);
                dok = good(mdup[a]);
                it.exp = {!pok && !dok, !pok && dok, mpri[a][31:0]};
                if (!pok && dok) begin nret++; fp[p] = 1'b1; end
                else if (pok && !dok) fd[p] = 1'b1;
            end
            sbq.push_back(it);
        end
        for (int p = 0; p < 2; p++) begin
            a = (p == 0) ? a0 : a1;
            if (fp[p]) mpri[a] = mdup[a];
            if (fd[p]) mdup[a] = mpri[a];
        end
        if (ie && !(w && wa == ia)) begin
            if (id) mdup[ia][ib] = ~mdup[ia][ib];
            else    mpri[ia][ib] = ~mpri[ia][ib];
        end
        if (w) begin mpri[wa] = mk(wd); mdup[wa] = mk(wd); end
        mcnt = (mcnt + nret > CMAX) ? CMAX : mcnt + nret;
        it.due = cyc + 1; it.port = 2; it.exp = 34'(mcnt); it.tag = {tag, " R8"};
        sbq.push_back(it);
    endtask

    task automatic rd(input logic [7:0] a0, input logic [7:0] a1, input string tag);
        op(1'b0, 8'd0, 32'd0, a0, a1, 1'b0, 1'b0, 8'd0, 6'd0, tag);
    endtask

    task automatic inj(input logic id, input logic [7:0] ia, input logic [5:0] ib, input string tag);
        op(1'b0, 8'd0, 32'd0, 8'd0, 8'd1, 1'b1, id, ia, ib, tag);
    endtask

    task automatic finish_run();
        $display("  test done: total=%0d bad=%0d", total, bad);
        $finish;
    endtask

    initial begin
        #(CLK_NS * 100000);
        total++; bad++;
        $display("FAIL watchdog expired");
        finish_run();
    end

    initial begin
        repeat (3) @(negedge clk);
        #1;
        check("R9 reset port A", {ra_fatal, ra_retry, ra_data}, 34'd0);
        check("R9 reset port B", {rb_fatal, rb_retry, rb_data}, 34'd0);
        check("R9 reset count", {30'd0, err_count}, 34'd0);
        @(negedge clk);
        rst_n = 1'b1;

        // R1: fill the whole array; port reads hit address 0 (bypass on first cycle).
        for (int i = 0; i < DEPTH; i++)
            op(1'b1, 8'(i), (i * 32'h9E3779B1) ^ 32'h5A5A0000, 8'd0, 8'd0,
               1'b0, 1'b0, 8'd0, 6'd0, "R1 fill");
        rd(8'd7, 8'd135, "R1 readback");
        // R2: write and two independent reads together.
        op(1'b1, 8'd5, 32'hCAFEF00D, 8'd10, 8'd135, 1'b0, 1'b0, 8'd0, 6'd0, "R2 concurrent");
        rd(8'd5, 8'd10, "R2 after write");
        // R4: same-cycle forwarding on both ports.
        op(1'b1, 8'd20, 32'h12345678, 8'd20, 8'd21, 1'b0, 1'b0, 8'd0, 6'd0, "R4 bypass A");
        op(1'b1, 8'd21, 32'h0BADBEEF, 8'd22, 8'd21, 1'b0, 1'b0, 8'd0, 6'd0, "R4 bypass B");
        // R5: primary data bit upset -> retry, then repaired.
        inj(1'b0, 8'd30, 6'd3, "R3 inject data bit");
        rd(8'd30, 8'd2, "R5 retry");
        rd(8'd3, 8'd30, "R5 repaired");
        // R3: parity bit of byte 1 upset.
        inj(1'b0, 8'd31, 6'd33, "R3 inject parity bit");
        rd(8'd4, 8'd31, "R3 parity upset R5");
        rd(8'd31, 8'd4, "R3 repaired R5");
        // R6: both copies bad.
        inj(1'b0, 8'd40, 6'd12, "R6 inject pri");
        inj(1'b1, 8'd40, 6'd35, "R6 inject dup");
        rd(8'd40, 8'd6, "R6 fatal");
        rd(8'd6, 8'd40, "R6 fatal again");
        // R7: shadow-only error is scrubbed silently.
        inj(1'b1, 8'd50, 6'd7, "R7 inject dup");
        rd(8'd50, 8'd8, "R7 silent");
        inj(1'b0, 8'd50, 6'd9, "R7 inject pri");
        rd(8'd50, 8'd8, "R7 retry not fatal");
        // R10: injection loses to a same-cycle write.
        op(1'b1, 8'd60, 32'hA5A55A5A, 8'd0, 8'd1, 1'b1, 1'b0, 8'd60, 6'd0, "R10 write vs inject");
        rd(8'd60, 8'd60, "R10 clean");
        // R8: both ports retry on the same word -> count +2.
        inj(1'b0, 8'd70, 6'd20, "R8 inject");
        rd(8'd70, 8'd70, "R8 dual retry");
        // R8: saturation.
        for (int k = 0; k < 16; k++) begin
            inj(1'b0, 8'(80 + k), 6'(k), "R8 sat inject");
            rd(8'(80 + k), 8'd9, "R8 sat retry");
        end
        rd(8'd40, 8'd81, "R8 fatal no count");
        @(negedge clk);
        wr_en = 1'b0; inj_en = 1'b0;
        repeat (3) @(negedge clk);
        #2;
        finish_run();
    end
endmodule